// File: doc/BRIEF.md
# Masked-Header ATM Loopback Cell Returner

The block sits on the cell path of a multi-PHY ATM interface. Received cells arrive as byte streams, 53 bytes each (four header bytes, one HEC byte, 48 payload bytes), with a start-of-cell marker on the first byte and the PHY address alongside. The four header bytes are compared with a programmable 32-bit pattern, bit by bit, where a 32-bit mask selects which bits take part. When loopback is enabled, a cell that matches is taken off the forward path and kept in a one-cell holding buffer. Every other cell leaves on the forward output unchanged, with a fixed delay of four cycles.

The held cell goes back out on the transmit side of the same interface to the PHY address it arrived on. It waits until the upstream cell source offers a cell for that address. The block then stalls the source, inserts the held cell and lets the source cell follow. A saturating counter records looped cells as they leave. Each exit also sets a sticky alarm. A read strobe clears the counter and the alarm. If a second match arrives while the buffer is in use, that cell is forwarded as normal traffic and a dropped-match pulse is raised.

Top module: `atm_lb_returner`

## Requirements
- R1: With `lb_en` set, a cell whose header bits equal `hdr_pattern` at every position where `hdr_mask` is 1 is captured. None of its bytes appear on the forward output. Bits where the mask is 0 are ignored. Header byte 0 is compared with bits 31:24.
- R2: A cell whose masked header differs in any compared bit leaves on the forward output byte for byte with its PHY address and start marker. Each byte appears exactly 4 cycles after it was presented. Input cells are presented on 53 consecutive valid cycles.
- R3: With `lb_en` clear, matching cells are forwarded as normal traffic. They are neither captured, returned nor counted.
- R4: A held cell is transmitted only when the source offers a cell start (`src_sop` with `src_valid`) for the held PHY address, at a source cell boundary. Source cells for other addresses pass first. During the insertion `src_ready` is low for 54 cycles: one idle cycle, then the 53 held bytes on `tx_*` with the original PHY address and `tx_sop` on the first byte. The source cell follows.
- R5: Only one cell is held. A matching cell that arrives while the buffer is filling, held or sending is forwarded unchanged. `match_drop` pulses once for it, in the cycle its first byte leaves on the forward output.
- R6: `lb_count` increments when the last byte of a looped cell leaves on `tx_*`, visible the next cycle. It does not change on capture.
- R7: Each looped-cell exit sets `lb_alarm`, which stays set. A `cnt_rd` pulse clears `lb_count` to 0 and `lb_alarm` to 0. An exit in the same cycle as a read wins over the clear.
- R8: `lb_count` is 8 bits and saturates at 255.
- R9: After reset, `fwd_valid`, `tx_valid`, `match_drop` and `lb_alarm` are 0, `lb_count` is 0, and `src_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lb_en | input | 1 | Loopback enable |
| hdr_pattern | input | 32 | Header pattern; bits 31:24 are header byte 0 |
| hdr_mask | input | 32 | Per-bit compare mask, 1 = compared |
| in_valid | input | 1 | Received byte valid |
| in_sop | input | 1 | First byte of a received cell |
| in_phy | input | 5 | PHY address of the received cell |
| in_data | input | 8 | Received byte |
| fwd_valid | output | 1 | Forwarded byte valid |
| fwd_sop | output | 1 | First byte of a forwarded cell |
| fwd_phy | output | 5 | PHY address of the forwarded cell |
| fwd_data | output | 8 | Forwarded byte |
| src_valid | input | 1 | Transmit source byte valid |
| src_sop | input | 1 | First byte of a source cell |
| src_phy | input | 5 | PHY address of the source cell |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Source byte accepted this cycle when high |
| tx_valid | output | 1 | Transmit byte valid |
| tx_sop | output | 1 | First byte of a transmitted cell |
| tx_phy | output | 5 | PHY address of the transmitted cell |
| tx_data | output | 8 | Transmitted byte |
| cnt_rd | input | 1 | Read strobe, clears counter and alarm |
| lb_count | output | 8 | Looped-cell count |
| lb_alarm | output | 1 | Sticky loopback alarm |
| match_drop | output | 1 | Pulse: a match was passed on because the buffer was busy |

## Verification
The hardest case to reach from the ports is a match that arrives while the buffer is in use. The first matching cell has to be captured and then kept in place, which means no source cell may be offered for its PHY address. The stimulus sends two matching cells back to back on different addresses and offers a source cell for the second address only. This shows the second cell was forwarded and not held. A source cell for the first address then brings out the original held cell intact. Saturation is reached by repeating the capture-and-return cycle 256 times.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  // Holding-buffer life cycle: idle, being written, waiting for a slot, draining.
  typedef enum logic [1:0] {
    BUF_EMPTY = 2'd0,
    BUF_FILL  = 2'd1,
    BUF_HELD  = 2'd2,
    BUF_SEND  = 2'd3
  } buf_state_e;
endpackage

// File: rtl/lbr_rst_sync.sv
module lbr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lbr_delay.sv
module lbr_delay #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH:0][W-1:0] stg;

  assign stg[0] = d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r_q <= '0;
      else        r_q <= stg[i];
    end
    assign stg[i+1] = r_q;
  end

  assign q = stg[DEPTH];
endmodule

// File: rtl/lbr_hdr_match.sv
module lbr_hdr_match #(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4,
  localparam int POS_W     = $clog2(CELL_BYTES),
  localparam int HDR_W     = 8 * HDR_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [7:0]       in_data,
  input  logic [HDR_W-1:0] pattern,
  input  logic [HDR_W-1:0] mask,
  output logic             hdr_done,
  output logic             hdr_hit
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);
  localparam logic [POS_W-1:0] HDR_LAST = POS_W'(HDR_BYTES - 1);

  logic [POS_W-1:0] pos_q, pos_d, pos_cur;
  logic [HDR_W-9:0] hdr_q, hdr_d;
  logic [HDR_W-1:0] hdr_full;
  logic             done_d, hit_d, done_q, hit_q;

  always_comb begin
    pos_cur  = in_sop ? '0 : pos_q;
    pos_d    = pos_q;
    hdr_d    = hdr_q;
    hdr_full = {hdr_q, in_data};
    if (in_valid) begin
      pos_d = (pos_cur == LAST_POS) ? '0 : pos_cur + 1'b1;
      if (pos_cur <= HDR_LAST) hdr_d = hdr_full[HDR_W-9:0];
    end
    done_d = in_valid && (pos_cur == HDR_LAST);
    hit_d  = ((hdr_full ^ pattern) & mask) == '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hdr_q  <= '0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      hdr_q  <= hdr_d;
      done_q <= done_d;
      hit_q  <= hit_d;
    end
  end

  assign hdr_done = done_q;
  assign hdr_hit  = hit_q;
endmodule

// File: rtl/lbr_cell_buf.sv
module lbr_cell_buf
  import lbr_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int PHY_W      = 5,
  localparam int POS_W     = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lb_en,
  input  logic             hdr_done,
  input  logic             hdr_hit,
  input  logic             d_valid,
  input  logic             d_sop,
  input  logic [PHY_W-1:0] d_phy,
  input  logic [7:0]       d_data,
  output logic             fwd_valid,
  output logic             fwd_sop,
  output logic [PHY_W-1:0] fwd_phy,
  output logic [7:0]       fwd_data,
  input  logic             src_valid,
  input  logic             src_sop,
  input  logic [PHY_W-1:0] src_phy,
  input  logic [7:0]       src_data,
  output logic             src_ready,
  output logic             tx_valid,
  output logic             tx_sop,
  output logic [PHY_W-1:0] tx_phy,
  output logic [7:0]       tx_data,
  output logic             drop,
  output logic             sending,
  output logic             exit_pulse
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

  buf_state_e       state_q, state_d;
  logic [PHY_W-1:0] held_q, held_d;
  logic [POS_W-1:0] rd_q, rd_d;
  logic [POS_W-1:0] wpos_q, wpos_d, wpos_cur;
  logic [POS_W-1:0] spos_q, spos_d, spos_cur;
  logic             route_q, route_d, route_cur;
  logic             capture, we, start, src_fire;
  logic [7:0]       mem [CELL_BYTES];

  // Routing decision for the cell whose first byte leaves the delay line now.
  always_comb begin
    capture   = hdr_done && hdr_hit && lb_en && (state_q == BUF_EMPTY);
    drop      = hdr_done && hdr_hit && lb_en && (state_q != BUF_EMPTY);
    route_cur = hdr_done ? capture : route_q;
    route_d   = route_cur;
    wpos_cur  = d_sop ? '0 : wpos_q;
    wpos_d    = wpos_q;
    if (d_valid) wpos_d = (wpos_cur == LAST_POS) ? '0 : wpos_cur + 1'b1;
    we        = d_valid && route_cur;
  end

  // Egress: held cell preempts a source cell for the same PHY at a boundary.
  always_comb begin
    start     = (state_q == BUF_HELD) && src_valid && src_sop &&
                (spos_q == '0) && (src_phy == held_q);
    src_ready = (state_q != BUF_SEND) && !start;
    src_fire  = src_valid && src_ready;
    spos_cur  = src_sop ? '0 : spos_q;
    spos_d    = spos_q;
    if (src_fire) spos_d = (spos_cur == LAST_POS) ? '0 : spos_cur + 1'b1;
  end

  always_comb begin
    state_d    = state_q;
    held_d     = held_q;
    rd_d       = rd_q;
    exit_pulse = 1'b0;
    unique case (state_q)
      BUF_EMPTY: if (capture) begin
        state_d = BUF_FILL;
        held_d  = d_phy;
      end
      BUF_FILL: if (we && (wpos_cur == LAST_POS)) state_d = BUF_HELD;
      BUF_HELD: if (start) begin
        state_d = BUF_SEND;
        rd_d    = '0;
      end
      BUF_SEND: begin
        if (rd_q == LAST_POS) begin
          state_d    = BUF_EMPTY;
          exit_pulse = 1'b1;
        end else begin
          rd_d = rd_q + 1'b1;
        end
      end
      default: state_d = BUF_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BUF_EMPTY;
      held_q  <= '0;
      rd_q    <= '0;
      wpos_q  <= '0;
      spos_q  <= '0;
      route_q <= 1'b0;
    end else begin
      state_q <= state_d;
      held_q  <= held_d;
      rd_q    <= rd_d;
      wpos_q  <= wpos_d;
      spos_q  <= spos_d;
      route_q <= route_d;
    end
  end

  // Cell storage: write-enabled, no reset.
  always_ff @(posedge clk) begin
    if (we) mem[wpos_cur] <= d_data;
  end

  assign sending   = (state_q == BUF_SEND);
  assign fwd_valid = d_valid && !route_cur;
  assign fwd_sop   = d_sop;
  assign fwd_phy   = d_phy;
  assign fwd_data  = d_data;

  always_comb begin
    if (sending) begin
      tx_valid = 1'b1;
      tx_sop   = (rd_q == '0);
      tx_phy   = held_q;
      tx_data  = mem[rd_q];
    end else begin
      tx_valid = src_fire;
      tx_sop   = src_sop;
      tx_phy   = src_phy;
      tx_data  = src_data;
    end
  end
endmodule

// File: rtl/lbr_counter.sv
module lbr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exit_pulse,
  input  logic             rd,
  output logic [CNT_W-1:0] count,
  output logic             alarm
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_base;
  logic             alarm_q, alarm_d;

  always_comb begin
    cnt_base = rd ? '0 : cnt_q;
    cnt_d    = cnt_base;
    if (exit_pulse && (cnt_base != CNT_MAX)) cnt_d = cnt_base + 1'b1;
    alarm_d  = exit_pulse ? 1'b1 : (rd ? 1'b0 : alarm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      alarm_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      alarm_q <= alarm_d;
    end
  end

  assign count = cnt_q;
  assign alarm = alarm_q;
endmodule

// File: rtl/atm_lb_returner.sv
module atm_lb_returner #(
  parameter int CELL_BYTES = 53,
  parameter int HDR_BYTES  = 4,
  parameter int PHY_W      = 5,
  parameter int CNT_W      = 8,
  localparam int HDR_W     = 8 * HDR_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lb_en,
  input  logic [HDR_W-1:0] hdr_pattern,
  input  logic [HDR_W-1:0] hdr_mask,
  input  logic             in_valid,
  input  logic             in_sop,
  input  logic [PHY_W-1:0] in_phy,
  input  logic [7:0]       in_data,
  output logic             fwd_valid,
  output logic             fwd_sop,
  output logic [PHY_W-1:0] fwd_phy,
  output logic [7:0]       fwd_data,
  input  logic             src_valid,
  input  logic             src_sop,
  input  logic [PHY_W-1:0] src_phy,
  input  logic [7:0]       src_data,
  output logic             src_ready,
  output logic             tx_valid,
  output logic             tx_sop,
  output logic [PHY_W-1:0] tx_phy,
  output logic [7:0]       tx_data,
  input  logic             cnt_rd,
  output logic [CNT_W-1:0] lb_count,
  output logic             lb_alarm,
  output logic             match_drop
);
  localparam int PIPE_W = 2 + PHY_W + 8;

  logic              rst_q_n;
  logic              hdr_done, hdr_hit;
  logic [PIPE_W-1:0] pipe_in, pipe_out;
  logic              d_valid, d_sop;
  logic [PHY_W-1:0]  d_phy;
  logic [7:0]        d_data;
  logic              buf_sending, buf_exit;

  lbr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  lbr_hdr_match #(
    .CELL_BYTES (CELL_BYTES),
    .HDR_BYTES  (HDR_BYTES)
  ) u_match (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .in_valid (in_valid),
    .in_sop   (in_sop),
    .in_data  (in_data),
    .pattern  (hdr_pattern),
    .mask     (hdr_mask),
    .hdr_done (hdr_done),
    .hdr_hit  (hdr_hit)
  );

  // The delay equals the header length so the decision meets byte 0.
  assign pipe_in = {in_valid, in_sop, in_phy, in_data};

  lbr_delay #(
    .DEPTH (HDR_BYTES),
    .W     (PIPE_W)
  ) u_delay (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d     (pipe_in),
    .q     (pipe_out)
  );

  assign {d_valid, d_sop, d_phy, d_data} = pipe_out;

  lbr_cell_buf #(
    .CELL_BYTES (CELL_BYTES),
    .PHY_W      (PHY_W)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .lb_en      (lb_en),
    .hdr_done   (hdr_done),
    .hdr_hit    (hdr_hit),
    .d_valid    (d_valid),
    .d_sop      (d_sop),
    .d_phy      (d_phy),
    .d_data     (d_data),
    .fwd_valid  (fwd_valid),
    .fwd_sop    (fwd_sop),
    .fwd_phy    (fwd_phy),
    .fwd_data   (fwd_data),
    .src_valid  (src_valid),
    .src_sop    (src_sop),
    .src_phy    (src_phy),
    .src_data   (src_data),
    .src_ready  (src_ready),
    .tx_valid   (tx_valid),
    .tx_sop     (tx_sop),
    .tx_phy     (tx_phy),
    .tx_data    (tx_data),
    .drop       (match_drop),
    .sending    (buf_sending),
    .exit_pulse (buf_exit)
  );

  lbr_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .exit_pulse (buf_exit),
    .rd         (cnt_rd),
    .count      (lb_count),
    .alarm      (lb_alarm)
  );
endmodule

// File: rtl/atm_lb_returner_chk.sv
module atm_lb_returner_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       in_data,
  input logic             fwd_valid,
  input logic             fwd_sop,
  input logic [7:0]       fwd_data,
  input logic             src_ready,
  input logic             tx_valid,
  input logic             buf_sending,
  input logic             cnt_rd,
  input logic             match_drop,
  input logic [CNT_W-1:0] lb_count,
  input logic             lb_alarm
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // R2: forwarded bytes are the input bytes of four cycles earlier.
  p_fwd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> fwd_data == $past(in_data, 4));

  // R4: while the held cell drains, the source is stalled and tx carries data.
  p_src_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_sending |-> (!src_ready && tx_valid));

  // R5: a dropped match shows up as the start of a forwarded cell.
  p_drop_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_drop |-> (fwd_valid && fwd_sop));

  // R6: without a read the count only steps by one.
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_rd) && (lb_count != $past(lb_count))) |->
      (lb_count == $past(lb_count) + 1'b1));

  // R7: the alarm rises together with an exit that counts or saturates.
  p_alarm_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lb_alarm) && !$past(cnt_rd)) |->
      ((lb_count == $past(lb_count) + 1'b1) || (lb_count == CNT_MAX)));

  // R8: a saturated count stays put until read.
  p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lb_count) == CNT_MAX) && !$past(cnt_rd)) |-> (lb_count == CNT_MAX));
endmodule

bind atm_lb_returner atm_lb_returner_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_data     (in_data),
  .fwd_valid   (fwd_valid),
  .fwd_sop     (fwd_sop),
  .fwd_data    (fwd_data),
  .src_ready   (src_ready),
  .tx_valid    (tx_valid),
  .buf_sending (buf_sending),
  .cnt_rd      (cnt_rd),
  .match_drop  (match_drop),
  .lb_count    (lb_count),
  .lb_alarm    (lb_alarm)
);

// File: tb/atm_lb_returner_test.sv
`timescale 1ns/1ps
module atm_lb_returner_test;
  localparam logic [31:0] PAT     = 32'h0A1B_2C3D;
  localparam logic [31:0] MSK     = 32'hFFFF_0FF0;
  localparam logic [31:0] HDR_HIT = 32'h0A1B_FC3E;  // differs only in unmasked bits
  localparam logic [31:0] HDR_MIS = 32'h0A1B_2D3D;  // differs in a compared bit
  localparam logic [31:0] HDR_SRC = 32'h5555_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lb_en;
  logic [31:0] hdr_pattern, hdr_mask;
  logic        in_valid, in_sop;
  logic [4:0]  in_phy;
  logic [7:0]  in_data;
  logic        fwd_valid, fwd_sop;
  logic [4:0]  fwd_phy;
  logic [7:0]  fwd_data;
  logic        src_valid, src_sop;
  logic [4:0]  src_phy;
  logic [7:0]  src_data;
  logic        src_ready;
  logic        tx_valid, tx_sop;
  logic [4:0]  tx_phy;
  logic [7:0]  tx_data;
  logic        cnt_rd;
  logic [7:0]  lb_count;
  logic        lb_alarm;
  logic        match_drop;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int drive_cyc = 0;
  int fwd_first_cyc = -1;
  int drop_cnt = 0;
  int stall_cnt = 0;
  logic [7:0] fwd_d[$];
  logic [4:0] fwd_p[$];
  bit         fwd_s[$];
  logic [7:0] tx_d[$];
  logic [4:0] tx_p[$];
  bit         tx_s[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  atm_lb_returner uut (
    .clk(clk), .rst_n(rst_n), .lb_en(lb_en),
    .hdr_pattern(hdr_pattern), .hdr_mask(hdr_mask),
    .in_valid(in_valid), .in_sop(in_sop), .in_phy(in_phy), .in_data(in_data),
    .fwd_valid(fwd_valid), .fwd_sop(fwd_sop), .fwd_phy(fwd_phy), .fwd_data(fwd_data),
    .src_valid(src_valid), .src_sop(src_sop), .src_phy(src_phy), .src_data(src_data),
    .src_ready(src_ready),
    .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_phy(tx_phy), .tx_data(tx_data),
    .cnt_rd(cnt_rd), .lb_count(lb_count), .lb_alarm(lb_alarm), .match_drop(match_drop)
  );

  function automatic logic [7:0] cell_byte(input int i, input logic [31:0] h, input logic [7:0] s);
    if (i < 4)       return h[31-8*i -: 8];
    else if (i == 4) return 8'h00;
    else             return s + 8'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Output monitor: samples away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (fwd_valid) begin
        fwd_d.push_back(fwd_data); fwd_p.push_back(fwd_phy); fwd_s.push_back(fwd_sop);
        if (fwd_sop && fwd_first_cyc < 0) fwd_first_cyc = cyc;
      end
      if (tx_valid) begin
        tx_d.push_back(tx_data); tx_p.push_back(tx_phy); tx_s.push_back(tx_sop);
      end
      if (match_drop) drop_cnt++;
      if (src_valid && !src_ready) stall_cnt++;
    end
  end

  task automatic clear_mon();
    fwd_d.delete(); fwd_p.delete(); fwd_s.delete();
    tx_d.delete(); tx_p.delete(); tx_s.delete();
    fwd_first_cyc = -1; drop_cnt = 0; stall_cnt = 0;
  endtask

  task automatic send_cell(input logic [4:0] phy, input logic [31:0] h, input logic [7:0] s);
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      if (i == 0) drive_cyc = cyc;
      in_valid = 1'b1; in_sop = (i == 0); in_phy = phy; in_data = cell_byte(i, h, s);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
  endtask

  task automatic send_src(input logic [4:0] phy, input logic [7:0] s);
    int i = 0;
    while (i < 53) begin
      @(negedge clk);
      src_valid = 1'b1; src_sop = (i == 0); src_phy = phy; src_data = cell_byte(i, HDR_SRC, s);
      #1;
      if (src_ready) i++;
    end
    @(negedge clk);
    src_valid = 1'b0; src_sop = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_cell(input bit use_tx, input int off, input logic [31:0] h,
                          input logic [7:0] s, input logic [4:0] phy,
                          input string req, input string what);
    int bad = 0;
    int sz = use_tx ? tx_d.size() : fwd_d.size();
    if (sz < off + 53) bad = 999;
    else begin
      for (int i = 0; i < 53; i++) begin
        logic [7:0] d;
        logic [4:0] p;
        bit so;
        d  = use_tx ? tx_d[off+i] : fwd_d[off+i];
        p  = use_tx ? tx_p[off+i] : fwd_p[off+i];
        so = use_tx ? tx_s[off+i] : fwd_s[off+i];
        if (d !== cell_byte(i, h, s) || p !== phy || so !== (i == 0)) bad++;
      end
    end
    chk(bad == 0, req, what, bad, 0);
  endtask

  task automatic t_reset();
    #1;
    chk(!fwd_valid && !tx_valid && !match_drop, "R9", "outputs idle after reset",
        {fwd_valid, tx_valid, match_drop}, 0);
    chk(lb_count == 0 && !lb_alarm, "R9", "count and alarm clear", {lb_alarm, lb_count}, 0);
    chk(src_ready == 1'b1, "R9", "src_ready high", src_ready, 1);
  endtask

  task automatic t_forward();
    clear_mon();
    lb_en = 1'b1;
    send_cell(5'd4, HDR_MIS, 8'h10);
    repeat (8) @(negedge clk);
    cmp_cell(1'b0, 0, HDR_MIS, 8'h10, 5'd4, "R2", "mismatch cell forwarded intact");
    chk(fwd_d.size() == 53, "R2", "forward byte count", fwd_d.size(), 53);
    chk(fwd_first_cyc - drive_cyc == 4, "R2", "forward latency", fwd_first_cyc - drive_cyc, 4);
    chk(lb_count == 0, "R2", "no count on forward", lb_count, 0);
  endtask

  task automatic t_disabled();
    clear_mon();
    lb_en = 1'b0;
    send_cell(5'd7, HDR_HIT, 8'h20);
    repeat (8) @(negedge clk);
    cmp_cell(1'b0, 0, HDR_HIT, 8'h20, 5'd7, "R3", "match forwarded when disabled");
    send_src(5'd7, 8'h30);
    chk(tx_d.size() == 53, "R3", "no loop cell returned", tx_d.size(), 53);
    chk(lb_count == 0, "R3", "no count when disabled", lb_count, 0);
    lb_en = 1'b1;
  endtask

  task automatic t_loop();
    clear_mon();
    send_cell(5'd7, HDR_HIT, 8'h50);
    repeat (8) @(negedge clk);
    chk(fwd_d.size() == 0, "R1", "masked match not forwarded", fwd_d.size(), 0);
    chk(lb_count == 0, "R6", "no count on capture", lb_count, 0);
    send_src(5'd3, 8'h60);
    chk(tx_d.size() == 53 && stall_cnt == 0, "R4", "other PHY source passes untouched",
        tx_d.size(), 53);
    cmp_cell(1'b1, 0, HDR_SRC, 8'h60, 5'd3, "R4", "other PHY source cell");
    chk(lb_count == 0, "R6", "no count before exit", lb_count, 0);
    send_src(5'd7, 8'h70);
    cmp_cell(1'b1, 53, HDR_HIT, 8'h50, 5'd7, "R1", "captured cell returned on same PHY");
    cmp_cell(1'b1, 106, HDR_SRC, 8'h70, 5'd7, "R4", "source cell follows loop cell");
    chk(stall_cnt == 54, "R4", "source stall cycles", stall_cnt, 54);
    chk(lb_count == 1, "R6", "count after exit", lb_count, 1);
    chk(lb_alarm == 1'b1, "R7", "alarm set on exit", lb_alarm, 1);
  endtask

  task automatic t_busy();
    clear_mon();
    send_cell(5'd2, HDR_HIT, 8'h40);
    send_cell(5'd9, HDR_HIT, 8'h80);
    repeat (8) @(negedge clk);
    cmp_cell(1'b0, 0, HDR_HIT, 8'h80, 5'd9, "R5", "second match forwarded");
    chk(fwd_d.size() == 53, "R5", "only second cell forwarded", fwd_d.size(), 53);
    chk(drop_cnt == 1, "R5", "drop pulse count", drop_cnt, 1);
    send_src(5'd9, 8'h90);
    chk(tx_d.size() == 53, "R5", "second match not held", tx_d.size(), 53);
    send_src(5'd2, 8'hA0);
    cmp_cell(1'b1, 53, HDR_HIT, 8'h40, 5'd2, "R5", "first held cell intact");
    chk(lb_count == 2, "R6", "count after second exit", lb_count, 2);
  endtask

  task automatic t_read();
    chk(lb_alarm == 1'b1, "R7", "alarm sticky before read", lb_alarm, 1);
    @(negedge clk); cnt_rd = 1'b1;
    @(negedge clk); cnt_rd = 1'b0;
    #1;
    chk(lb_count == 0, "R7", "count cleared by read", lb_count, 0);
    chk(lb_alarm == 1'b0, "R7", "alarm cleared by read", lb_alarm, 0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 256; k++) begin
      send_cell(5'd1, HDR_HIT, 8'(k));
      repeat (6) @(negedge clk);
      send_src(5'd1, 8'h11);
    end
    chk(lb_count == 8'hFF, "R8", "count saturates at 255", lb_count, 255);
    chk(lb_alarm == 1'b1, "R8", "alarm set while saturated", lb_alarm, 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; lb_en = 1'b0; hdr_pattern = PAT; hdr_mask = MSK;
    in_valid = 1'b0; in_sop = 1'b0; in_phy = '0; in_data = '0;
    src_valid = 1'b0; src_sop = 1'b0; src_phy = '0; src_data = '0;
    cnt_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_forward();
    t_disabled();
    t_loop();
    t_busy();
    t_read();
    t_saturate();
    finish_run();
  end
endmodule